// File: doc/BRIEF.md
# Tone Transceiver Bus Register Interface

This block is the processor-facing register file of a dual-tone signalling transceiver. A 4-bit bus with an active-low select, a register-select line, a read/write line and an access strobe reaches four register functions. Writes go to a transmit code register or to control. Reads return the last received digit code or a status word. Two control registers share one bus address. A one-shot redirect bit in the first register steers exactly one later control write into the second one.

The generator and detector sit beside the block and talk to it through sideband signals. The generator sends a one-cycle "ready for more data" event. The detector sends a one-cycle "new digit" event with its 4-bit code, a level that marks a validated tone, and a hard-limited call-progress square wave. In the other direction the block drives the transmit code, a load pulse and the mode bits. It also drives one active-low interrupt pin with open-drain meaning: 1 releases the pin, 0 pulls it low. In test mode and call-progress mode that pin is given over to other signals. All logic runs on `clk`. The bus strobe is sampled on that clock, and every cycle in which it is high while the block is selected is one access.

Top module: `xcvr_regif`

## Requirements
- R1: A write with `bus_rsel`=0 and `bus_rd`=0 loads `bus_wdata` into `tx_code` at that clock edge and raises `tx_load` for that one access cycle.
- R2: A new-digit event stores `rx_code` in the receive register. A read with `bus_rsel`=0 and `bus_rd`=1 returns that register on `bus_rdata` during the access cycle.
- R3: A control write (`bus_rsel`=1, `bus_rd`=0) with no redirect pending lands in control register A. Its bits are: bit0 tone output enable (`tone_en`), bit1 call-progress mode (1) or tone mode (0) (`cp_mode`), bit2 interrupt enable, bit3 redirect.
- R4: When register A is written with bit3=1, only the next control write lands in control register B. Every control write after that lands in A again.
- R5: The bits of control register B are: bit0 burst disable (0 = burst on, seen as `burst_en`=1), bit1 test mode, bit2 single-tone select (`single_tone`), bit3 column (1) or row (0) select (`col_sel`).
- R6: A status read (`bus_rsel`=1, `bus_rd`=1) returns bit0 interrupt occurred, bit1 transmit register empty, bit2 receive register full, and bit3 the inverse of `steer_valid`.
- R7: Status bits 0 to 2 clear at the edge that ends a status read, and the value read is the one before the clear. An event that arrives in that same cycle is kept.
- R8: A ready event sets transmit-empty (and interrupt-occurred) only while burst mode is on. Transmit-empty is forced clear while burst mode is off.
- R9: With interrupts enabled, tone mode and test mode off, `irq_n` is 0 while interrupt-occurred is set, and returns to 1 after the status read.
- R10: In tone mode with test mode set, `irq_n` shows the inverse of `steer_valid`, whether or not interrupts are enabled.
- R11: In call-progress mode with interrupts enabled, `irq_n` follows `cp_wave`. New-digit events are ignored: the receive register and the receive-full flag stay as they were.
- R12: Reset clears both control registers, the redirect, the data registers and all flags. This leaves tone mode and burst mode selected, the tone output off and `irq_n` at 1.
- R13: With `bus_cs_n`=1 or `bus_stb`=0 no access takes place: nothing is written and no flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, 0 selects |
| bus_stb | input | 1 | Access strobe, one access per cycle high |
| bus_rsel | input | 1 | Register select: 0 data, 1 control/status |
| bus_rd | input | 1 | 1 read, 0 write |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid during a read access |
| tx_code | output | 4 | Digit code for the generator |
| tx_load | output | 1 | High during a transmit-code write access |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode selected |
| burst_en | output | 1 | Burst mode on |
| single_tone | output | 1 | Single-tone generation selected |
| col_sel | output | 1 | Column tone selected in single-tone mode |
| rx_new | input | 1 | One-cycle new-digit event from the detector |
| rx_code | input | 4 | Code of the new digit |
| tx_ready | input | 1 | One-cycle ready event from the generator |
| steer_valid | input | 1 | Validated tone present |
| cp_wave | input | 1 | Hard-limited call-progress signal |
| irq_n | output | 1 | Interrupt pin, 0 pulls low |

## Verification
The bench builds the block with its default parameters: a 4-bit bus, chip select active at 0, digit events blocked in call-progress mode, and the combinational pin path. With these values every pin source can be watched on the cycle after the register change that selects it. The same settings let the bench walk the redirect sequence through both control registers and put an event and a status read into the same cycle. The registered-pin variant is left to its own elaboration.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

   // control register A, packed msb..lsb as bits 3..0
   typedef struct packed {
      logic redirect;
      logic irq_en;
      logic cp_mode;
      logic tone_en;
   } cra_t;

   // control register B, packed msb..lsb as bits 3..0
   typedef struct packed {
      logic col_sel;
      logic single;
      logic test;
      logic burst_off;
   } crb_t;

   // access kinds, encoded as {register select, read}
   typedef enum logic [1:0] {
      ACC_TX_WR = 2'b00,
      ACC_RX_RD = 2'b01,
      ACC_CR_WR = 2'b10,
      ACC_ST_RD = 2'b11
   } acc_e;

   localparam int unsigned CTL_BITS = 4;

endpackage

// File: rtl/xrf_decode.sv
module xrf_decode #(
   parameter bit CS_SEL_LVL = 1'b0
) (
   input  logic cs,
   input  logic stb,
   input  logic rsel,
   input  logic rd,
   output logic acc_tx_wr,
   output logic acc_rx_rd,
   output logic acc_cr_wr,
   output logic acc_st_rd
);
   import xrf_pkg::*;

   logic  selected;
   logic  active;
   acc_e  kind;

   generate
      if (CS_SEL_LVL == 1'b0) begin : g_sel_low
         assign selected = ~cs;
      end else begin : g_sel_high
         assign selected = cs;
      end
   endgenerate

   assign active = selected & stb;
   assign kind   = acc_e'({rsel, rd});

   always_comb begin
      acc_tx_wr = 1'b0;
      acc_rx_rd = 1'b0;
      acc_cr_wr = 1'b0;
      acc_st_rd = 1'b0;
      if (active) begin
         unique case (kind)
            ACC_TX_WR: acc_tx_wr = 1'b1;
            ACC_RX_RD: acc_rx_rd = 1'b1;
            ACC_CR_WR: acc_cr_wr = 1'b1;
            ACC_ST_RD: acc_st_rd = 1'b1;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/xrf_ctrl.sv
module xrf_ctrl #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cr_wr,
   input  logic [DATA_W-1:0] wdata,
   output xrf_pkg::cra_t     cra,
   output xrf_pkg::crb_t     crb,
   output logic              redirect
);
   import xrf_pkg::*;

   localparam int unsigned RD_BIT = CTL_BITS - 1;

   cra_t cra_q;
   crb_t crb_q;
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cra_q  <= '0;
         crb_q  <= '0;
         pend_q <= 1'b0;
      end else if (cr_wr) begin
         if (pend_q) begin
            crb_q  <= crb_t'(wdata[CTL_BITS-1:0]);
            pend_q <= 1'b0;
         end else begin
            cra_q  <= cra_t'(wdata[CTL_BITS-1:0]);
            pend_q <= wdata[RD_BIT];
         end
      end
   end

   assign cra      = cra_q;
   assign crb      = crb_q;
   assign redirect = pend_q;
endmodule

// File: rtl/xrf_status.sv
module xrf_status (
   input  logic clk,
   input  logic rst_n,
   input  logic st_rd,
   input  logic burst_en,
   input  logic rx_evt,
   input  logic tx_evt,
   output logic st_irq,
   output logic st_txe,
   output logic st_rxf
);
   logic tx_hit;
   logic irq_d, txe_d, rxf_d;

   assign tx_hit = tx_evt & burst_en;

   always_comb begin
      // receive-full: event wins over the clear of a read in the same cycle
      if (rx_evt)      rxf_d = 1'b1;
      else if (st_rd)  rxf_d = 1'b0;
      else             rxf_d = st_rxf;

      if (tx_hit)                 txe_d = 1'b1;
      else if (st_rd | ~burst_en) txe_d = 1'b0;
      else                        txe_d = st_txe;

      if (rx_evt | tx_hit) irq_d = 1'b1;
      else if (st_rd)      irq_d = 1'b0;
      else                 irq_d = st_irq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_irq <= 1'b0;
         st_txe <= 1'b0;
         st_rxf <= 1'b0;
      end else begin
         st_irq <= irq_d;
         st_txe <= txe_d;
         st_rxf <= rxf_d;
      end
   end
endmodule

// File: rtl/xrf_irqmux.sv
module xrf_irqmux #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_en,
   input  logic cp_mode,
   input  logic test_mode,
   input  logic st_irq,
   input  logic steer_valid,
   input  logic cp_wave,
   output logic pin_n
);
   logic sel_n;

   always_comb begin
      if (cp_mode) begin
         sel_n = irq_en ? cp_wave : 1'b1;
      end else if (test_mode) begin
         sel_n = ~steer_valid;
      end else if (irq_en) begin
         sel_n = ~st_irq;
      end else begin
         sel_n = 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b1;
            else        pin_q <= sel_n;
         end
         assign pin_n = pin_q;
      end else begin : g_comb
         assign pin_n = sel_n;
      end
   endgenerate
endmodule

// File: rtl/xcvr_regif.sv
module xcvr_regif #(
   parameter int unsigned DATA_W      = 4,
   parameter bit          CS_SEL_LVL  = 1'b0,
   parameter bit          RX_CP_BLOCK = 1'b1,
   parameter bit          IRQ_OUT_REG = 1'b0,
   parameter logic [3:0]  IDLE_RD     = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_stb,
   input  logic              bus_rsel,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] tx_code,
   output logic              tx_load,
   output logic              tone_en,
   output logic              cp_mode,
   output logic              burst_en,
   output logic              single_tone,
   output logic              col_sel,
   input  logic              rx_new,
   input  logic [DATA_W-1:0] rx_code,
   input  logic              tx_ready,
   input  logic              steer_valid,
   input  logic              cp_wave,
   output logic              irq_n
);
   import xrf_pkg::*;

   localparam int unsigned ST_BITS = 4;

   generate
      if (DATA_W != CTL_BITS) begin : g_bad_width
         $error("xcvr_regif: DATA_W must equal the 4-bit register width");
      end
   endgenerate

   logic acc_tx_wr, acc_rx_rd, acc_cr_wr, acc_st_rd;
   cra_t cra;
   crb_t crb;
   logic redirect;
   logic st_irq, st_txe, st_rxf;
   logic rx_evt;
   logic [DATA_W-1:0] tx_q, rx_hold;
   logic [ST_BITS-1:0] st_word;

   xrf_decode #(.CS_SEL_LVL(CS_SEL_LVL)) u_dec (
      .cs        (bus_cs_n),
      .stb       (bus_stb),
      .rsel      (bus_rsel),
      .rd        (bus_rd),
      .acc_tx_wr (acc_tx_wr),
      .acc_rx_rd (acc_rx_rd),
      .acc_cr_wr (acc_cr_wr),
      .acc_st_rd (acc_st_rd)
   );

   xrf_ctrl #(.DATA_W(DATA_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cr_wr    (acc_cr_wr),
      .wdata    (bus_wdata),
      .cra      (cra),
      .crb      (crb),
      .redirect (redirect)
   );

   generate
      if (RX_CP_BLOCK) begin : g_rx_gate
         assign rx_evt = rx_new & ~cra.cp_mode;
      end else begin : g_rx_open
         assign rx_evt = rx_new;
      end
   endgenerate

   xrf_status u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_rd    (acc_st_rd),
      .burst_en (~crb.burst_off),
      .rx_evt   (rx_evt),
      .tx_evt   (tx_ready),
      .st_irq   (st_irq),
      .st_txe   (st_txe),
      .st_rxf   (st_rxf)
   );

   xrf_irqmux #(.OUT_REG(IRQ_OUT_REG)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_en      (cra.irq_en),
      .cp_mode     (cra.cp_mode),
      .test_mode   (crb.test),
      .st_irq      (st_irq),
      .steer_valid (steer_valid),
      .cp_wave     (cp_wave),
      .pin_n       (irq_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_hold <= '0;
      end else begin
         if (acc_tx_wr) tx_q    <= bus_wdata;
         if (rx_evt)    rx_hold <= rx_code;
      end
   end

   assign st_word = {~steer_valid, st_rxf, st_txe, st_irq};

   always_comb begin
      if (acc_rx_rd)      bus_rdata = rx_hold;
      else if (acc_st_rd) bus_rdata = st_word;
      else                bus_rdata = IDLE_RD;
   end

   assign tx_code     = tx_q;
   assign tx_load     = acc_tx_wr;
   assign tone_en     = cra.tone_en;
   assign cp_mode     = cra.cp_mode;
   assign burst_en    = ~crb.burst_off;
   assign single_tone = crb.single;
   assign col_sel     = crb.col_sel;
endmodule

// File: rtl/xcvr_regif_chk.sv
module xcvr_regif_chk #(
   parameter int unsigned DATA_W      = 4,
   parameter bit          RX_CP_BLOCK = 1'b1,
   parameter bit          IRQ_OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_tx_wr,
   input logic              acc_rx_rd,
   input logic              acc_cr_wr,
   input logic              acc_st_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] tx_code,
   input logic              redirect,
   input logic              rx_new,
   input logic              tx_ready,
   input logic              cp_mode,
   input logic              irq_en,
   input logic              test_mode,
   input logic [DATA_W-1:0] rx_hold,
   input logic              burst_en,
   input logic              st_irq,
   input logic              st_txe,
   input logic              st_rxf,
   input logic [7:0]        ctl_word,
   input logic              irq_n
);
   logic no_acc;
   assign no_acc = !(acc_tx_wr | acc_rx_rd | acc_cr_wr | acc_st_rd);

   p_txwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_tx_wr |=> tx_code == $past(bus_wdata));

   p_redirect_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_cr_wr && redirect) |=> !redirect);

   p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_st_rd && !rx_new && !tx_ready) |=> (!st_irq && !st_rxf && !st_txe));

   p_txe_burst_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_en |=> !st_txe);

   p_no_access_r13: assert property (@(posedge clk) disable iff (!rst_n)
      no_acc |=> ($stable(tx_code) && $stable(ctl_word)));

   generate
      if (RX_CP_BLOCK) begin : g_cp_chk
         p_cp_rx_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_new && cp_mode) |=> $stable(rx_hold));
         p_rx_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_new && !cp_mode) |=> st_rxf);
      end
      if (!IRQ_OUT_REG) begin : g_irq_chk
         p_irq_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_new && !cp_mode && irq_en && !test_mode && !acc_cr_wr) |=> !irq_n);
      end
   endgenerate
endmodule

bind xcvr_regif xcvr_regif_chk #(
   .DATA_W      (DATA_W),
   .RX_CP_BLOCK (RX_CP_BLOCK),
   .IRQ_OUT_REG (IRQ_OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_tx_wr (acc_tx_wr),
   .acc_rx_rd (acc_rx_rd),
   .acc_cr_wr (acc_cr_wr),
   .acc_st_rd (acc_st_rd),
   .bus_wdata (bus_wdata),
   .tx_code   (tx_code),
   .redirect  (redirect),
   .rx_new    (rx_new),
   .tx_ready  (tx_ready),
   .cp_mode   (cp_mode),
   .irq_en    (cra.irq_en),
   .test_mode (crb.test),
   .rx_hold   (rx_hold),
   .burst_en  (burst_en),
   .st_irq    (st_irq),
   .st_txe    (st_txe),
   .st_rxf    (st_rxf),
   .ctl_word  ({cra, crb}),
   .irq_n     (irq_n)
);

// File: tb/xcvr_regif_tb.sv
`timescale 1ns/1ps
module xcvr_regif_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs_n = 1'b1, bus_stb = 1'b0, bus_rsel = 1'b0, bus_rd = 1'b0;
   logic [3:0] bus_wdata = '0;
   logic [3:0] bus_rdata, tx_code;
   logic       tx_load, tone_en, cp_mode, burst_en, single_tone, col_sel;
   logic       rx_new = 1'b0;
   logic [3:0] rx_code = '0;
   logic       tx_ready = 1'b0, steer_valid = 1'b0, cp_wave = 1'b1;
   logic       irq_n;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] last_rd;
   logic       last_load;

   always #2.5 clk = ~clk;

   xcvr_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_stb(bus_stb),
      .bus_rsel(bus_rsel), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tx_code(tx_code), .tx_load(tx_load),
      .tone_en(tone_en), .cp_mode(cp_mode), .burst_en(burst_en),
      .single_tone(single_tone), .col_sel(col_sel), .rx_new(rx_new),
      .rx_code(rx_code), .tx_ready(tx_ready), .steer_valid(steer_valid),
      .cp_wave(cp_wave), .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus access: inputs set at a falling edge, read data captured
   // before the rising edge, released at the next falling edge
   task automatic access(input logic rs, input logic rw, input logic [3:0] wd);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_stb = 1'b1; bus_rsel = rs; bus_rd = rw; bus_wdata = wd;
      #1 last_rd = bus_rdata; last_load = tx_load;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_stb = 1'b0;
      #1;
   endtask

   task automatic rx_pulse(input logic [3:0] code);
      @(negedge clk);
      rx_new = 1'b1; rx_code = code;
      @(negedge clk);
      rx_new = 1'b0;
      #1;
   endtask

   task automatic ready_pulse();
      @(negedge clk);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   // vector: {rs, rw, wdata, chk_sel, expected}
   // chk_sel 0 read data, 1 tx_code, 2 {cp_mode,tone_en}, 3 {col,single,test,~burst}
   typedef struct packed {
      logic       rs;
      logic       rw;
      logic [3:0] wd;
      logic [1:0] sel;
      logic [3:0] exp;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 4'h5, 2'd1, 4'h5},   // R1
      '{1'b0, 1'b0, 4'hC, 2'd1, 4'hC},   // R1
      '{1'b1, 1'b0, 4'h3, 2'd2, 4'h3},   // R3
      '{1'b1, 1'b0, 4'h8, 2'd2, 4'h0},   // R4 redirect armed
      '{1'b1, 1'b0, 4'hE, 2'd3, 4'hE},   // R5 lands in B
      '{1'b1, 1'b0, 4'h1, 2'd2, 4'h1},   // R4 back to A
      '{1'b1, 1'b0, 4'h9, 2'd2, 4'h1},   // R4 re-arm
      '{1'b1, 1'b0, 4'h1, 2'd3, 4'h1},   // R5 burst off
      '{1'b1, 1'b0, 4'h0, 2'd2, 4'h0},   // R4 to A
      '{1'b1, 1'b1, 4'h0, 2'd0, 4'h8}    // R6 status
   };

   logic [3:0] got;

   initial begin : watchdog
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      do_reset();
      // R12 reset state
      check("R12 irq_n", {3'b0, irq_n}, 4'h1);
      check("R12 modes", {tone_en, cp_mode, single_tone, col_sel}, 4'h0);
      check("R12 burst_en", {3'b0, burst_en}, 4'h1);
      check("R12 tx_code", tx_code, 4'h0);
      access(1'b1, 1'b1, 4'h0);
      check("R12 status", last_rd, 4'h8);

      for (int i = 0; i < NVEC; i++) begin
         access(VECS[i].rs, VECS[i].rw, VECS[i].wd);
         case (VECS[i].sel)
            2'd0: got = last_rd;
            2'd1: got = tx_code;
            2'd2: got = {2'b00, cp_mode, tone_en};
            default: got = {col_sel, single_tone, 1'b0, ~burst_en};
         endcase
         if (VECS[i].sel == 2'd3) got[1] = VECS[i].exp[1]; // test bit not on a port
         check($sformatf("vector %0d", i), got, VECS[i].exp);
      end
      access(1'b0, 1'b0, 4'h7);
      check("R1 tx_load", {3'b0, last_load}, 4'h1);

      do_reset();
      // R13 unselected or unstrobed accesses do nothing
      @(negedge clk);
      bus_cs_n = 1'b1; bus_stb = 1'b1; bus_rsel = 1'b0; bus_rd = 1'b0; bus_wdata = 4'hA;
      @(negedge clk);
      bus_cs_n = 1'b0; bus_stb = 1'b0; bus_rsel = 1'b1; bus_wdata = 4'h1;
      @(negedge clk);
      bus_cs_n = 1'b1; #1;
      check("R13 tx_code", tx_code, 4'h0);
      check("R13 tone_en", {3'b0, tone_en}, 4'h0);

      // R2 receive path
      rx_pulse(4'h7);
      access(1'b0, 1'b1, 4'h0);
      check("R2 rx read", last_rd, 4'h7);
      access(1'b1, 1'b1, 4'h0);
      check("R6 status after rx", last_rd, 4'hD);
      access(1'b1, 1'b1, 4'h0);
      check("R7 cleared", last_rd, 4'h8);

      // R9 interrupt pin
      access(1'b1, 1'b0, 4'h4);
      rx_pulse(4'h9);
      check("R9 irq low", {3'b0, irq_n}, 4'h0);
      access(1'b1, 1'b1, 4'h0);
      check("R9 status", last_rd, 4'hD);
      check("R9 irq released", {3'b0, irq_n}, 4'h1);

      // R8 transmit empty in burst mode
      ready_pulse();
      check("R8 irq on ready", {3'b0, irq_n}, 4'h0);
      access(1'b1, 1'b1, 4'h0);
      check("R8 txe set", last_rd, 4'hB);
      ready_pulse();
      access(1'b1, 1'b0, 4'hC);
      access(1'b1, 1'b0, 4'h1);
      check("R5 burst off", {3'b0, burst_en}, 4'h0);
      access(1'b1, 1'b1, 4'h0);
      check("R8 txe forced clear", last_rd, 4'h9);
      ready_pulse();
      access(1'b1, 1'b1, 4'h0);
      check("R8 ready ignored", last_rd, 4'h8);

      // R7 event in the same cycle as the status read
      @(negedge clk);
      bus_cs_n = 1'b0; bus_stb = 1'b1; bus_rsel = 1'b1; bus_rd = 1'b1;
      rx_new = 1'b1; rx_code = 4'h2;
      #1 last_rd = bus_rdata;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_stb = 1'b0; rx_new = 1'b0;
      check("R7 pre-clear value", last_rd, 4'h8);
      access(1'b1, 1'b1, 4'h0);
      check("R7 event kept", last_rd, 4'hD);

      // R10 test mode
      access(1'b1, 1'b0, 4'h8);
      access(1'b1, 1'b0, 4'h3);
      access(1'b1, 1'b0, 4'h0);
      @(negedge clk); steer_valid = 1'b1; #1;
      check("R10 pin low on valid", {3'b0, irq_n}, 4'h0);
      access(1'b1, 1'b1, 4'h0);
      check("R6 steer bit", last_rd, 4'h0);
      @(negedge clk); steer_valid = 1'b0; #1;
      check("R10 pin high on absent", {3'b0, irq_n}, 4'h1);

      // R11 call-progress mode
      access(1'b1, 1'b0, 4'h6);
      @(negedge clk); cp_wave = 1'b0; #1;
      check("R11 follows low", {3'b0, irq_n}, 4'h0);
      @(negedge clk); cp_wave = 1'b1; #1;
      check("R11 follows high", {3'b0, irq_n}, 4'h1);
      rx_pulse(4'h3);
      access(1'b0, 1'b1, 4'h0);
      check("R11 rx unchanged", last_rd, 4'h2);
      access(1'b1, 1'b1, 4'h0);
      check("R11 no rx full", last_rd, 4'h8);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule